// File: doc/BRIEF.md
# Dependency-Window Hazard Interlock

This block sits at the boundary between fetch and decode in a deep, strictly in-order pipeline. Decode, execute and writeback each take a configurable number of register stages. Fetch offers one instruction per cycle on a valid/ready channel. The instruction carries two source register indices, a destination index and a destination-write flag. The block remembers the destination of every instruction that is still in decode or execute, or is writing back. It withholds `in_ready` while an offered instruction reads any of those registers. In each cycle that it holds an instruction back, a bubble enters decode: the issue slot is empty and its valid bit is clear. It exposes a writeback tag, which is the destination of the instruction that is writing back in this cycle.

The hold is applied before decode, which is where operands are read. Fetch depth therefore adds nothing to the hazard window: the fetch stages of the consumer run at the same time as the later stages of the producer. Memory access is counted as part of execute, so it does not lengthen the window. The register file writes in the writeback cycle, and decode can read the new value in the next cycle.

Back-pressure rules: `in_ready` depends only on state inside the block and never on `in_valid`. An instruction transfers on a clock edge where both `in_valid` and `in_ready` are high. While `in_valid` is high and `in_ready` is low, fetch must keep its fields stable. The decode side has no ready signal, because the block issues at most one instruction or one bubble per cycle.

Top module: `hzd_interlock`

## Requirements
- R1: After reset, `iss_valid` and `wb_valid` are 0, `in_ready` is 1 and `stall` is 0.
- R2: If an instruction reads the destination of the instruction transferred just before it, exactly ID_DEPTH+EX_DEPTH bubbles separate the two in the issue stream.
- R3: If the producer was transferred k transfers earlier with no idle cycles between them, the consumer waits max(0, ID_DEPTH+EX_DEPTH+1-k) cycles.
- R4: Instructions whose sources are not written by any instruction in flight transfer on consecutive cycles.
- R5: An instruction with a destination-write flag of 0, or with destination register 0, never causes a stall. Reading register 0 never stalls either.
- R6: An instruction that writes a nonzero destination and transfers at edge E shows `wb_valid`=1 with `wb_dst` equal to its destination after edge E+ID_DEPTH+EX_DEPTH. No other cycle shows `wb_valid`=1.
- R7: `in_ready` is 0, and `stall` equals `in_valid`, in exactly the cycles where an offered source matches a destination in decode or execute. A held instruction issues only once.
- R8: Both sources are checked. A match on the second source alone causes the same stall as a match on the first.
- R9: After a transfer at edge E, `iss_valid`=1 during the following cycle, and `iss_src_a`, `iss_src_b`, `iss_dst` and `iss_dst_we` equal the fields that were transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch offers an instruction |
| in_ready | output | 1 | Block accepts the offered instruction |
| in_src_a | input | RIDX_W | First source register index |
| in_src_b | input | RIDX_W | Second source register index |
| in_dst | input | RIDX_W | Destination register index |
| in_dst_we | input | 1 | The instruction writes its destination |
| stall | output | 1 | An offered instruction is being held (a bubble is inserted) |
| iss_valid | output | 1 | Decode entry holds an instruction; 0 means a bubble |
| iss_src_a | output | RIDX_W | Issued first source |
| iss_src_b | output | RIDX_W | Issued second source |
| iss_dst | output | RIDX_W | Issued destination |
| iss_dst_we | output | 1 | Issued destination-write flag |
| wb_valid | output | 1 | An instruction writes back in this cycle |
| wb_dst | output | RIDX_W | Register written back in this cycle |

## Verification
Runs of independent instructions show that the block adds no cycles when no hazard exists. An adjacent dependency shows that the full bubble count is inserted. Producers two, three and seven transfers back show how the bubble count shrinks with distance and falls to zero at the edge of the window. A match on the second source alone checks that both comparators are in use. Writes to register 0 and non-writing instructions followed by readers check that such instructions leave no mark in the window. An idle gap before a dependent instruction checks that the wait is counted in cycles, not in instructions. For every issue and every writeback, the bench compares the cycle and the register against values from its own ready-time model.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // registered slots from decode entry through writeback
  function automatic int window_len(input int id_depth, input int ex_depth);
    return id_depth + ex_depth + 1;
  endfunction
  // slots compared against offered sources (writeback excluded)
  function automatic int hazard_len(input int id_depth, input int ex_depth);
    return id_depth + ex_depth;
  endfunction
endpackage

// File: rtl/hzd_window.sv
module hzd_window #(
  parameter int LEN = 6,
  parameter int RW  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_vld,
  input  logic [RW-1:0]          push_idx,
  output logic [LEN-1:0]         tag_vld,
  output logic [LEN-1:0][RW-1:0] tag_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_vld[0] <= 1'b0;
      tag_idx[0] <= '0;
    end else begin
      tag_vld[0] <= push_vld;
      tag_idx[0] <= push_vld ? push_idx : '0;
    end
  end

  for (genvar s = 1; s < LEN; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_vld[s] <= 1'b0;
        tag_idx[s] <= '0;
      end else begin
        tag_vld[s] <= tag_vld[s-1];
        tag_idx[s] <= tag_idx[s-1];
      end
    end
  end
endmodule

// File: rtl/hzd_match.sv
module hzd_match #(
  parameter int N  = 5,
  parameter int RW = 5
) (
  input  logic [N-1:0]         tag_vld,
  input  logic [N-1:0][RW-1:0] tag_idx,
  input  logic [RW-1:0]        src_a,
  input  logic [RW-1:0]        src_b,
  output logic                 hit
);
  logic [N-1:0] slot_hit;

  for (genvar s = 0; s < N; s++) begin : g_cmp
    assign slot_hit[s] = tag_vld[s] &&
                         ((tag_idx[s] == src_a) || (tag_idx[s] == src_b));
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock #(
  parameter int NUM_REGS = 32,
  parameter int IF_DEPTH = 3,
  parameter int ID_DEPTH = 2,
  parameter int EX_DEPTH = 3,
  localparam int RIDX_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RIDX_W-1:0] in_src_a,
  input  logic [RIDX_W-1:0] in_src_b,
  input  logic [RIDX_W-1:0] in_dst,
  input  logic              in_dst_we,
  output logic              stall,
  output logic              iss_valid,
  output logic [RIDX_W-1:0] iss_src_a,
  output logic [RIDX_W-1:0] iss_src_b,
  output logic [RIDX_W-1:0] iss_dst,
  output logic              iss_dst_we,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_dst
);
  localparam int WIN_LEN = hzd_pkg::window_len(ID_DEPTH, EX_DEPTH);
  localparam int HAZ_LEN = hzd_pkg::hazard_len(ID_DEPTH, EX_DEPTH);

  // fetch depth overlaps the producer and never widens the window
  if (IF_DEPTH < 1 || IF_DEPTH > 5 || ID_DEPTH < 1 || ID_DEPTH > 5 ||
      EX_DEPTH < 1 || EX_DEPTH > 5) begin : g_bad_cfg
    $error("stage depths must lie in 1..5");
  end

  logic [WIN_LEN-1:0]             tag_vld;
  logic [WIN_LEN-1:0][RIDX_W-1:0] tag_idx;
  logic                           hit;
  logic                           accept;
  logic                           push_vld;

  assign accept   = in_valid && in_ready;
  assign push_vld = accept && in_dst_we && (in_dst != '0);

  hzd_window #(.LEN(WIN_LEN), .RW(RIDX_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_vld (push_vld),
    .push_idx (in_dst),
    .tag_vld  (tag_vld),
    .tag_idx  (tag_idx)
  );

  hzd_match #(.N(HAZ_LEN), .RW(RIDX_W)) u_match (
    .tag_vld (tag_vld[HAZ_LEN-1:0]),
    .tag_idx (tag_idx[HAZ_LEN-1:0]),
    .src_a   (in_src_a),
    .src_b   (in_src_b),
    .hit     (hit)
  );

  assign in_ready = !hit;
  assign stall    = in_valid && hit;
  assign wb_valid = tag_vld[WIN_LEN-1];
  assign wb_dst   = tag_idx[WIN_LEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid  <= 1'b0;
      iss_src_a  <= '0;
      iss_src_b  <= '0;
      iss_dst    <= '0;
      iss_dst_we <= 1'b0;
    end else begin
      iss_valid <= accept;
      if (accept) begin
        iss_src_a  <= in_src_a;
        iss_src_b  <= in_src_b;
        iss_dst    <= in_dst;
        iss_dst_we <= in_dst_we;
      end else begin
        iss_dst_we <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hzd_interlock_chk.sv
module hzd_interlock_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [RW-1:0] in_src_a,
  input logic [RW-1:0] in_src_b,
  input logic [RW-1:0] in_dst,
  input logic          stall,
  input logic          iss_valid,
  input logic [RW-1:0] iss_src_a,
  input logic [RW-1:0] iss_dst,
  input logic          iss_dst_we,
  input logic          wb_valid,
  input logic [RW-1:0] wb_dst
);
  p_hold_gives_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> !iss_valid);

  p_accept_issues_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (iss_valid && iss_src_a == $past(in_src_a) &&
                                iss_dst == $past(in_dst)));

  p_adjacent_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_dst_we && iss_dst != '0 &&
     (in_src_a == iss_dst || in_src_b == iss_dst)) |-> !in_ready);

  p_wb_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_dst != '0));

  p_stall_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (in_valid && !in_ready));
endmodule

bind hzd_interlock hzd_interlock_chk #(.RW(RIDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_src_a   (in_src_a),
  .in_src_b   (in_src_b),
  .in_dst     (in_dst),
  .stall      (stall),
  .iss_valid  (iss_valid),
  .iss_src_a  (iss_src_a),
  .iss_dst    (iss_dst),
  .iss_dst_we (iss_dst_we),
  .wb_valid   (wb_valid),
  .wb_dst     (wb_dst)
);

// File: tb/hzd_interlock_bench.sv
module hzd_interlock_bench;
  localparam int NREG = 32;
  localparam int IDD  = 2;
  localparam int EXD  = 3;
  localparam int RW   = $clog2(NREG);

  typedef struct {
    int t;
    int a;
    int b;
    int d;
    int we;
  } iss_item_t;

  typedef struct {
    int t;
    int d;
  } wb_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [RW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic in_dst_we = 1'b0;
  logic stall, iss_valid, iss_dst_we, wb_valid;
  logic [RW-1:0] iss_src_a, iss_src_b, iss_dst, wb_dst;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit reported = 0;
  int rdy [NREG];
  iss_item_t iss_q[$];
  wb_item_t  wb_q[$];

  always #5 clk = ~clk;

  hzd_interlock #(.NUM_REGS(NREG), .IF_DEPTH(3), .ID_DEPTH(IDD), .EX_DEPTH(EXD))
  u_hzd_interlock (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .in_dst_we(in_dst_we), .stall(stall), .iss_valid(iss_valid),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
    .iss_dst_we(iss_dst_we), .wb_valid(wb_valid), .wb_dst(wb_dst)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // driver: offer one instruction, hold it for the predicted stall
  task automatic drive(input int a, input int b, input int d, input int we, input int idle);
    int exp_t;
    iss_item_t it;
    wb_item_t w;
    repeat (idle) @(negedge clk);
    exp_t = cyc + 1;
    if (rdy[a] > exp_t) exp_t = rdy[a];
    if (rdy[b] > exp_t) exp_t = rdy[b];
    in_valid = 1'b1;
    in_src_a = RW'(a);
    in_src_b = RW'(b);
    in_dst = RW'(d);
    in_dst_we = we[0];
    #1;
    while (cyc + 1 < exp_t) begin
      chk(in_ready == 1'b0 && stall == 1'b1, "R7 hold while dependent (in_ready)", in_ready, 0);
      @(negedge clk);
      #1;
    end
    chk(in_ready == 1'b1 && stall == 1'b0, "R7 release when clear (in_ready)", in_ready, 1);
    it.t = exp_t; it.a = a; it.b = b; it.d = d; it.we = we;
    iss_q.push_back(it);
    if (we != 0 && d != 0) begin
      rdy[d] = exp_t + IDD + EXD + 1;
      w.t = exp_t + IDD + EXD;
      w.d = d;
      wb_q.push_back(w);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: issue stream and writeback tags
  always @(negedge clk) begin
    if (rst_n) begin
      if (iss_valid) begin
        if (iss_q.size() == 0) begin
          chk(0, "R7 extra issue (cycle)", cyc, -1);
        end else begin
          iss_item_t e;
          e = iss_q.pop_front();
          chk(cyc == e.t, "R2 R3 R4 R5 R8 issue cycle", cyc, e.t);
          chk(int'(iss_src_a) == e.a && int'(iss_src_b) == e.b &&
              int'(iss_dst) == e.d && int'(iss_dst_we) == e.we,
              "R9 issued fields (dst)", iss_dst, e.d);
        end
      end
      if (wb_valid) begin
        if (wb_q.size() == 0) begin
          chk(0, "R6 R5 unexpected writeback (dst)", wb_dst, -1);
        end else begin
          wb_item_t w;
          w = wb_q.pop_front();
          chk(cyc == w.t, "R6 writeback cycle", cyc, w.t);
          chk(int'(wb_dst) == w.d, "R6 writeback dst", wb_dst, w.d);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired (cycle)", cyc, 0);
    summary();
  end

  initial begin
    for (int r = 0; r < NREG; r++) rdy[r] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(iss_valid == 1'b0, "R1 reset iss_valid", iss_valid, 0);
    chk(wb_valid == 1'b0, "R1 reset wb_valid", wb_valid, 0);
    chk(in_ready == 1'b1 && stall == 1'b0, "R1 reset in_ready", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    // R4: independent back-to-back
    drive(10, 11, 1, 1, 0);
    drive(10, 11, 2, 1, 0);
    drive(10, 11, 3, 1, 0);
    drive(10, 11, 4, 1, 0);
    // R2: adjacent dependency
    drive(4, 0, 14, 1, 0);
    // R3: producer three transfers back
    drive(0, 0, 5, 1, 0);
    drive(0, 0, 6, 1, 0);
    drive(0, 0, 7, 1, 0);
    drive(5, 0, 15, 1, 0);
    // R3: producer two back
    drive(0, 0, 16, 1, 0);
    drive(0, 0, 17, 1, 0);
    drive(16, 0, 18, 1, 0);
    // R8: second source only
    drive(0, 0, 8, 1, 0);
    drive(0, 8, 19, 1, 0);
    // R5: dst 0 and non-writer never stall
    drive(0, 0, 0, 1, 0);
    drive(0, 0, 20, 1, 0);
    drive(0, 0, 9, 0, 0);
    drive(9, 9, 21, 1, 0);
    // R3: producer seven back, outside the window
    drive(0, 0, 12, 1, 0);
    for (int i = 0; i < 6; i++) drive(0, 0, 22 + i, 1, 0);
    drive(12, 0, 28, 1, 0);
    // R3: idle gap shortens the wait
    drive(0, 0, 13, 1, 0);
    drive(13, 0, 29, 1, 3);
    repeat (IDD + EXD + 4) @(negedge clk);
    chk(iss_q.size() == 0, "R9 missing issues (left)", iss_q.size(), 0);
    chk(wb_q.size() == 0, "R6 missing writebacks (left)", wb_q.size(), 0);
    summary();
  end
endmodule